// File: doc/BRIEF.md
# Serial-Clock Locked Ramp Pulse Generator with Bank Stagger

This block produces the one-cycle ramp-start pulse that times the PWM ramp of every converter channel. While the serial clock is toggling, the block counts its rising edges modulo eight and emits one pulse per eight edges, so the ramp runs at one eighth of the serial clock rate. Both the serial clock and the free-run oscillator arrive as plain levels. They are sampled by a fast core clock through a two-stage synchroniser, and only their rising edges count.

The initialization command (`init_stb`) sets the phase of the divider. A device strapped to the high bank (`bank_hi` = 1) reloads its phase to 0. A device on the low bank reloads to 4, so two paired devices fed the same serial clock and command start their ramps four serial clocks apart. That stagger splits the input ripple between them. Reset, which models under-voltage, clears the phase to 0 for every bank, so the stagger is lost until the next command. The enable pin has no effect on the divider. When the serial clock stops, a watchdog counts free-run edges, and after a set number of them the pulse source moves to a divider on the free-run oscillator.

Top module: `sync_ramp_gen`

## Requirements
- R1: During reset and in the cycle after it, `ramp_start` is 0. After reset, the first pulse follows the 8th serial-clock rising edge, whatever the level of `bank_hi`.
- R2: While the serial clock runs, exactly one `ramp_start` pulse, one core cycle wide, occurs per 8 serial-clock rising edges.
- R3: After `init_stb` with `bank_hi` = 1, the next pulse follows the 8th serial-clock rising edge and then every 8th one.
- R4: After `init_stb` with `bank_hi` = 0, the next pulse follows the 4th serial-clock rising edge and then every 8th one.
- R5: A serial-clock rise is counted on the third core clock edge after `sclk_in` goes high. If `init_stb` is high in that cycle, the reload wins: that rise is not counted and produces no pulse.
- R6: Toggling `en_in` neither produces, suppresses nor shifts any pulse.
- R7: With no serial-clock rise, the first 4 free-run rising edges (LOSS_TIMEOUT) produce no pulse. Each later free-run edge produces one pulse (FRUN_DIV = 1).
- R8: The first serial-clock rise after a loss returns the pulse source to the serial divider, with its phase kept from before the loss. Later free-run edges below the timeout produce no pulse.
- R9: A reset after a low-bank command discards the stagger, and the next pulse follows the 8th serial-clock rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst | input | 1 | Synchronous active-high reset (under-voltage) |
| sclk_in | input | 1 | Serial clock level |
| frun_in | input | 1 | Free-run oscillator level |
| init_stb | input | 1 | One-cycle initialization command strobe |
| bank_hi | input | 1 | Bank-select strap, 1 = high bank |
| en_in | input | 1 | Output enable pin (does not affect the divider) |
| ramp_start | output | 1 | One-cycle ramp-start pulse |

## Verification
The reload from an initialization command can fall in the same core cycle in which a synchronised serial-clock rise advances the phase. To provoke this, the bench raises `init_stb` two core edges after raising `sclk_in`, so the strobe is held across the counting edge. The result is judged in two ways. No pulse may appear in that serial period. The low-bank device must then pulse on the 4th following rise, which shows that the colliding rise was dropped and not added on top of the reload.

// File: rtl/sync_div_pkg.sv
package sync_div_pkg;

    localparam int DEF_DIV_RATIO   = 8;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_LOSS_TMO    = 4;
    localparam int DEF_FRUN_DIV    = 1;

    typedef enum logic {
        SRC_SCLK = 1'b0,
        SRC_FRUN = 1'b1
    } ramp_src_e;

    typedef struct packed {
        logic frun_rise;
        logic sclk_rise;
    } edge_evt_t;

    function automatic int stagger_offset(input int ratio);
        return ratio / 2;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            last_q <= sh_q[STAGES-1];
        end
    end

    assign rise = sh_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/phase_div.sv
module phase_div
    import sync_div_pkg::*;
#(
    parameter int DIV_RATIO = DEF_DIV_RATIO
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic init_stb,
    input  logic bank_hi,
    output logic wrap
);
    localparam int PW = $clog2(DIV_RATIO);
    localparam logic [PW-1:0] LAST_PH = PW'(DIV_RATIO - 1);
    localparam logic [PW-1:0] STAG_PH = PW'(stagger_offset(DIV_RATIO));

    logic [PW-1:0] phase_q;
    logic [PW-1:0] load_ph;

    assign load_ph = bank_hi ? '0 : STAG_PH;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (init_stb) begin
            phase_q <= load_ph;
        end else if (tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign wrap = tick & ~init_stb & (phase_q == LAST_PH);

    // R3 R4
    init_load_chk: assert property (@(posedge clk) disable iff (rst)
        init_stb |=> (phase_q == ($past(bank_hi) ? '0 : STAG_PH)));

    // R9
    uv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase_q == '0));

endmodule

// File: rtl/loss_mon.sv
module loss_mon #(
    parameter int TIMEOUT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_rise,
    input  logic frun_rise,
    output logic lost
);
    localparam int LW = $clog2(TIMEOUT + 1);

    logic [LW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
            lost   <= 1'b0;
        end else if (sclk_rise) begin
            idle_q <= '0;
            lost   <= 1'b0;
        end else if (frun_rise && !lost) begin
            if (idle_q == LW'(TIMEOUT - 1)) begin
                lost <= 1'b1;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    // R8
    sclk_return_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> !lost);

endmodule

// File: rtl/frun_div.sv
module frun_div #(
    parameter int FRUN_DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic pulse
);
    localparam int CW = (FRUN_DIV > 1) ? $clog2(FRUN_DIV) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(FRUN_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
        end
    end

    assign pulse = tick & (cnt_q == LAST_C);

endmodule

// File: rtl/sync_ramp_gen.sv
module sync_ramp_gen
    import sync_div_pkg::*;
#(
    parameter int DIV_RATIO    = DEF_DIV_RATIO,
    parameter int SYNC_STAGES  = DEF_SYNC_STAGES,
    parameter int LOSS_TIMEOUT = DEF_LOSS_TMO,
    parameter int FRUN_DIV     = DEF_FRUN_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic frun_in,
    input  logic init_stb,
    input  logic bank_hi,
    input  logic en_in,
    output logic ramp_start
);
    localparam int N_SRC = 2;

    logic [N_SRC-1:0] raw_lvl;
    logic [N_SRC-1:0] raw_rise;
    edge_evt_t        evt;
    logic             div_wrap;
    logic             frun_pulse;
    logic             lost;
    ramp_src_e        src;

    assign raw_lvl = {frun_in, sclk_in};

    for (genvar g = 0; g < N_SRC; g++) begin : g_sync
        edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lvl[g]),
            .rise (raw_rise[g])
        );
    end

    assign evt = '{frun_rise: raw_rise[1], sclk_rise: raw_rise[0]};

    phase_div #(.DIV_RATIO(DIV_RATIO)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .tick     (evt.sclk_rise),
        .init_stb (init_stb),
        .bank_hi  (bank_hi),
        .wrap     (div_wrap)
    );

    loss_mon #(.TIMEOUT(LOSS_TIMEOUT)) u_loss (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (evt.sclk_rise),
        .frun_rise (evt.frun_rise),
        .lost      (lost)
    );

    frun_div #(.FRUN_DIV(FRUN_DIV)) u_frun (
        .clk   (clk),
        .rst   (rst),
        .tick  (evt.frun_rise),
        .pulse (frun_pulse)
    );

    assign src = lost ? SRC_FRUN : SRC_SCLK;

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_start <= 1'b0;
        end else begin
            ramp_start <= (src == SRC_FRUN) ? frun_pulse : div_wrap;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ramp_start);

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        ramp_start |=> !ramp_start);

    // R5
    init_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (init_stb && evt.sclk_rise && !lost) |=> !ramp_start);

    // R6
    en_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        ((en_in != $past(en_in)) && !lost && !div_wrap) |=> !ramp_start);

    // R7
    frun_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (lost && frun_pulse) |=> ramp_start);

endmodule

// File: tb/test_sync_ramp_gen.sv
module test_sync_ramp_gen;

    localparam int TMO = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_in = 1'b0;
    logic frun_in = 1'b0;
    logic init_stb = 1'b0;
    logic bank_hi = 1'b1;
    logic en_in = 1'b1;
    logic ramp_start;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sync_ramp_gen i_sync_ramp_gen (
        .clk        (clk),
        .rst        (rst),
        .sclk_in    (sclk_in),
        .frun_in    (frun_in),
        .init_stb   (init_stb),
        .bank_hi    (bank_hi),
        .en_in      (en_in),
        .ramp_start (ramp_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one serial-clock period (8 core cycles), returns pulses seen
    task automatic sclk_period(output int n, input bit with_init);
        n = 0;
        sclk_in = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            n += int'(ramp_start);
            if (with_init && k == 2) init_stb = 1'b1;
            if (k == 3) init_stb = 1'b0;
            if (k == 4) sclk_in = 1'b0;
        end
    endtask

    // one free-run period (10 core cycles)
    task automatic frun_period(output int n);
        n = 0;
        frun_in = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            n += int'(ramp_start);
            if (k == 5) frun_in = 1'b0;
        end
    endtask

    task automatic init_cmd(input bit bank);
        bank_hi = bank;
        init_stb = 1'b1;
        @(negedge clk);
        init_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_seq(input int n, input int first, input string req);
        int p;
        for (int k = 1; k <= n; k++) begin
            int e;
            sclk_period(p, 1'b0);
            e = (k >= first && ((k - first) % 8) == 0) ? 1 : 0;
            chk(p == e, req, p, e);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        bank_hi = 1'b0;
        repeat (4) @(negedge clk);
        chk(ramp_start == 1'b0, "R1", int'(ramp_start), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ramp_start == 1'b0, "R1", int'(ramp_start), 0);
        expect_seq(17, 8, "R1");
    endtask

    task automatic t_bank_hi;
        init_cmd(1'b1);
        expect_seq(25, 8, "R3 R2");
    endtask

    task automatic t_bank_lo;
        init_cmd(1'b0);
        expect_seq(20, 4, "R4");
    endtask

    task automatic t_collide;
        int p;
        bank_hi = 1'b0;
        sclk_period(p, 1'b1);
        chk(p == 0, "R5", p, 0);
        expect_seq(12, 4, "R5");
    endtask

    task automatic t_enable;
        int p;
        init_cmd(1'b1);
        for (int k = 1; k <= 17; k++) begin
            int e;
            en_in = ~en_in;
            sclk_period(p, 1'b0);
            e = (k == 8 || k == 16) ? 1 : 0;
            chk(p == e, "R6", p, e);
        end
        en_in = 1'b1;
    endtask

    task automatic t_uv;
        int p;
        init_cmd(1'b0);
        sclk_period(p, 1'b0);
        sclk_period(p, 1'b0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_seq(9, 8, "R9");
    endtask

    task automatic t_loss;
        int p;
        init_cmd(1'b1);
        for (int k = 1; k <= 8; k++) begin
            int e;
            frun_period(p);
            e = (k > TMO) ? 1 : 0;
            chk(p == e, "R7", p, e);
        end
        sclk_period(p, 1'b0);
        chk(p == 0, "R8", p, 0);
        frun_period(p);
        chk(p == 0, "R8", p, 0);
        expect_seq(8, 7, "R8");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_bank_hi();
        t_bank_lo();
        t_collide();
        t_enable();
        t_uv();
        t_loss();
        finish_run();
    end

endmodule